// File: doc/BRIEF.md
# Flash Block Protection Controller

This block holds the write-protection state of a bank of flash erase blocks. Each block carries a lock bit and a lock-down bit. A command port with a block index accepts three operations: lock a block, unlock a block, and lock a block down. A global write-protect input, sampled on every clock, decides whether lock-down is enforced. While the input is low, a locked-down block stays locked. While it is high, lock-down is suspended and such a block can be unlocked.

Changes on the write-protect input act on every locked-down block at once. A falling edge forces each of them locked and remembers the lock value it had just before. A rising edge gives that remembered value back. The state after a rising edge therefore depends on what happened before the falling edge that preceded it. The erase and program sequencer uses the per-block writable vector to decide whether a request may go ahead. A read index selects one block whose lock and lock-down bits appear on a two-bit configuration word.

Top module: `lockctl_top`

## Requirements
- R1: After reset every block is locked with its lock-down bit clear, so `writable` is all zeros and each in-range configuration word reads 2'b01.
- R2: A lock command (`cmdOp` = 2'b01) with `cmdValid` high locks the indexed block from the next clock edge on.
- R3: An unlock command (`cmdOp` = 2'b10) unlocks an indexed block whose lock-down bit is clear. `writable[i]` is always the inverse of block i's lock bit.
- R4: A lock-down command (`cmdOp` = 2'b11) sets both the lock-down bit and the lock bit of the indexed block in the same cycle.
- R5: While write-protect is low, an unlock command on a locked-down block leaves it locked.
- R6: While write-protect is high, an unlock command unlocks the indexed block whatever its lock-down bit.
- R7: On a high-to-low change of `wpPin`, every block with its lock-down bit set becomes locked.
- R8: On a low-to-high change of `wpPin`, every locked-down block takes back the lock value it had just before the previous falling edge. A block that was locked down while the pin was low comes back locked.
- R9: Nothing changes for `cmdValid` low, for `cmdOp` = 2'b00, or for a block index at or above the number of blocks.
- R10: `cfgWord` bit 0 reports the selected block's lock bit and bit 1 its lock-down bit. An out-of-range `rdBlk` reads 2'b00.
- R11: When a command and a `wpPin` change fall in the same cycle, the command is judged against the level before the change, and the change is then applied to the command's result.
- R12: No command clears a lock-down bit. Only reset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | Operation: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmdBlk | input | IDX_W | Block index the command targets |
| wpPin | input | 1 | Write-protect level; low enforces lock-down |
| rdBlk | input | IDX_W | Block index shown on `cfgWord` |
| writable | output | NUM_BLOCKS | One bit per block, high when erase or program is allowed |
| cfgWord | output | 2 | {lock-down, lock} of the block selected by `rdBlk` |

## Verification
The commands are first applied with the pin held low, then with it held high. On a locked-down block the two levels give opposite results for an unlock, which separates the enforcing level from the suspended one. A fall, rise, fall, rise sequence is applied to a block that was unlocked during the high phase. Another block is locked down while the pin is low. After the final rise the first block must come back unlocked and the second locked, which shows that the remembered value is restored rather than a fixed one. A final case puts an unlock and a falling edge in the same cycle. Its result after the next rise differs depending on whether the command saw the old level or the new one.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_DOWN   = 2'b11
  } lockOp_e;

  // strobes from control to the per-block state bank
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
    logic wpHigh;   // level seen by commands this cycle
    logic wpFall;
    logic wpRise;
  } lockStrobe_t;

endpackage

// File: rtl/lockctl_ctrl.sv
module lockctl_ctrl
  import lockctl_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [IDX_W-1:0]      cmdBlk,
  input  logic                  wpPin,
  output lockStrobe_t           strobe,
  output logic [NUM_BLOCKS-1:0] selVec,
  output logic                  wpLevel
);

  lockOp_e opDec;
  logic    wpQ;
  logic    cmdLive;

  assign opDec   = lockOp_e'(cmdOp);
  assign cmdLive = cmdValid && (opDec != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wpQ <= 1'b0;
    else        wpQ <= wpPin;
  end

  assign wpLevel = wpQ;

  always_comb begin
    strobe         = '0;
    strobe.setLock = cmdLive && (opDec == OP_LOCK);
    strobe.clrLock = cmdLive && (opDec == OP_UNLOCK);
    strobe.setDown = cmdLive && (opDec == OP_DOWN);
    strobe.wpHigh  = wpQ;
    strobe.wpFall  = wpQ && !wpPin;
    strobe.wpRise  = !wpQ && wpPin;
  end

  // indices at or above NUM_BLOCKS match no block
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_sel
    assign selVec[i] = cmdLive && (int'(cmdBlk) == i);
  end

endmodule

// File: rtl/lockctl_bank.sv
module lockctl_bank
  import lockctl_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lockStrobe_t           strobe,
  input  logic [NUM_BLOCKS-1:0] selVec,
  input  logic [IDX_W-1:0]      rdBlk,
  output logic [NUM_BLOCKS-1:0] lockVec,
  output logic [NUM_BLOCKS-1:0] downVec,
  output logic [1:0]            cfgWord
);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    logic lockQ, downQ, saveQ;
    logic lockCmd, downCmd, saveCmd;
    logic lockNxt, saveNxt;

    // stage 1: command against the pre-edge level
    always_comb begin
      lockCmd = lockQ;
      downCmd = downQ;
      saveCmd = saveQ;
      if (selVec[i]) begin
        if (strobe.setLock) lockCmd = 1'b1;
        if (strobe.clrLock && (!downQ || strobe.wpHigh)) lockCmd = 1'b0;
        if (strobe.setDown) begin
          downCmd = 1'b1;
          lockCmd = 1'b1;
          saveCmd = 1'b1;
        end
      end
    end

    // stage 2: pin edge applied to the command result
    always_comb begin
      lockNxt = lockCmd;
      saveNxt = saveCmd;
      if (downCmd && strobe.wpFall) begin
        saveNxt = lockCmd;
        lockNxt = 1'b1;
      end
      if (downCmd && strobe.wpRise) lockNxt = saveCmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lockQ <= 1'b1;
        downQ <= 1'b0;
        saveQ <= 1'b1;
      end else begin
        lockQ <= lockNxt;
        downQ <= downCmd;
        saveQ <= saveNxt;
      end
    end

    assign lockVec[i] = lockQ;
    assign downVec[i] = downQ;
  end

  always_comb begin
    cfgWord = 2'b00;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (int'(rdBlk) == i) cfgWord = {downVec[i], lockVec[i]};
    end
  end

endmodule

// File: rtl/lockctl_top.sv
module lockctl_top
  import lockctl_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [IDX_W-1:0]      cmdBlk,
  input  logic                  wpPin,
  input  logic [IDX_W-1:0]      rdBlk,
  output logic [NUM_BLOCKS-1:0] writable,
  output logic [1:0]            cfgWord
);

  lockStrobe_t           strobe;
  logic [NUM_BLOCKS-1:0] selVec;
  logic [NUM_BLOCKS-1:0] lockVec;
  logic [NUM_BLOCKS-1:0] downVec;
  logic                  wpLevel;

  lockctl_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlk(cmdBlk), .wpPin(wpPin), .strobe(strobe), .selVec(selVec),
    .wpLevel(wpLevel)
  );

  lockctl_bank #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .selVec(selVec),
    .rdBlk(rdBlk), .lockVec(lockVec), .downVec(downVec), .cfgWord(cfgWord)
  );

  assign writable = ~lockVec;

endmodule

// File: rtl/lockctl_chk.sv
module lockctl_chk #(
  parameter int NUM_BLOCKS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmdValid,
  input logic [1:0]            cmdOp,
  input logic                  wpPin,
  input logic                  wpQ,
  input logic [NUM_BLOCKS-1:0] selVec,
  input logic [NUM_BLOCKS-1:0] lockVec,
  input logic [NUM_BLOCKS-1:0] downVec
);

  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(downVec) & ~downVec) == '0)); // R12

  AST_DOWN_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ((downVec & ~$past(downVec)) != '0) |-> $past(cmdValid && (cmdOp == 2'b11))); // R4

  AST_DOWN_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!wpPin && !wpQ) |=> (($past(lockVec & downVec) & ~lockVec) == '0)); // R5

  AST_FALL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wpQ && !wpPin) |=> ((downVec & ~lockVec) == '0)); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdValid && (wpPin == wpQ)) |=> ($stable(lockVec) && $stable(downVec))); // R9

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(selVec)); // R9

endmodule

bind lockctl_top lockctl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .wpPin(wpPin), .wpQ(wpLevel), .selVec(selVec), .lockVec(lockVec),
  .downVec(downVec)
);

// File: tb/lockctl_tb.sv
`timescale 1ns/100ps
module lockctl_top_tb_top;

  localparam int N  = 6;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdOp = 2'b00;
  logic [IW-1:0] cmdBlk = '0;
  logic          wpPin = 1'b0;
  logic [IW-1:0] rdBlk = '0;
  logic [N-1:0]  writable;
  logic [1:0]    cfgWord;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  lockctl_top #(.NUM_BLOCKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlk(cmdBlk), .wpPin(wpPin), .rdBlk(rdBlk),
    .writable(writable), .cfgWord(cfgWord)
  );

  // one cycle of stimulus; state is settled at the following negedge
  task automatic apply(input bit vld, input logic [1:0] op, input int blk, input bit wp);
    @(negedge clk);
    cmdValid = vld;
    cmdOp    = op;
    cmdBlk   = IW'(blk);
    wpPin    = wp;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp    = 2'b00;
  endtask

  task automatic chkCfg(input int blk, input logic [1:0] exp, input string req);
    rdBlk = IW'(blk);
    #0.5;
    nChecks++;
    if (cfgWord !== exp) begin
      nFails++;
      $display("FAIL %s: cfgWord blk %0d = %b, expected %b", req, blk, cfgWord, exp);
    end
    if (blk < N) begin
      nChecks++;
      if (writable[blk] !== ~exp[0]) begin
        nFails++;
        $display("FAIL %s: writable[%0d] = %b, expected %b", req, blk, writable[blk], ~exp[0]);
      end
    end
  endtask

  task automatic chkWr(input logic [N-1:0] exp, input string req);
    #0.5;
    nChecks++;
    if (writable !== exp) begin
      nFails++;
      $display("FAIL %s: writable = %b, expected %b", req, writable, exp);
    end
  endtask

  task automatic t_reset;
    for (int b = 0; b < N; b++) chkCfg(b, 2'b01, "R1");
    chkWr('0, "R1");
    chkCfg(7, 2'b00, "R10");
  endtask

  task automatic t_basic;
    apply(1'b1, 2'b10, 2, 1'b0);
    chkCfg(2, 2'b00, "R3");
    chkWr(6'b000100, "R3");
    apply(1'b1, 2'b01, 2, 1'b0);
    chkCfg(2, 2'b01, "R2");
  endtask

  task automatic t_lockdown;
    apply(1'b1, 2'b10, 1, 1'b0);
    chkCfg(1, 2'b00, "R3");
    apply(1'b1, 2'b11, 1, 1'b0);
    chkCfg(1, 2'b11, "R4");
    apply(1'b1, 2'b10, 1, 1'b0);
    chkCfg(1, 2'b11, "R5");
  endtask

  task automatic t_wpHigh;
    apply(1'b0, 2'b00, 0, 1'b1);             // rise: saved value was locked
    chkCfg(1, 2'b11, "R8");
    apply(1'b1, 2'b10, 1, 1'b1);
    chkCfg(1, 2'b10, "R6");
    apply(1'b1, 2'b01, 1, 1'b1);
    chkCfg(1, 2'b11, "R12");                 // lock keeps lock-down
    apply(1'b1, 2'b10, 1, 1'b1);
    chkCfg(1, 2'b10, "R12");                 // unlock keeps lock-down
  endtask

  task automatic t_history;
    apply(1'b0, 2'b00, 0, 1'b0);             // fall
    chkCfg(1, 2'b11, "R7");
    chkCfg(2, 2'b01, "R7");
    apply(1'b0, 2'b00, 0, 1'b1);             // rise: restore unlocked
    chkCfg(1, 2'b10, "R8");
    apply(1'b0, 2'b00, 0, 1'b0);             // fall
    apply(1'b1, 2'b11, 3, 1'b0);             // lock-down while low
    chkCfg(3, 2'b11, "R4");
    apply(1'b0, 2'b00, 0, 1'b1);             // rise
    chkCfg(1, 2'b10, "R8");
    chkCfg(3, 2'b11, "R8");
  endtask

  task automatic t_ignore;
    apply(1'b1, 2'b00, 0, 1'b1);
    chkCfg(0, 2'b01, "R9");
    apply(1'b1, 2'b10, 6, 1'b1);
    apply(1'b1, 2'b10, 7, 1'b1);
    chkWr(6'b000010, "R9");
    apply(1'b0, 2'b10, 0, 1'b1);
    chkCfg(0, 2'b01, "R9");
    chkCfg(6, 2'b00, "R10");
  endtask

  task automatic t_sameCycle;
    apply(1'b1, 2'b10, 3, 1'b0);             // unlock judged high, then fall
    chkCfg(3, 2'b11, "R11");
    chkCfg(1, 2'b11, "R7");
    apply(1'b0, 2'b00, 0, 1'b1);             // rise restores unlocked
    chkCfg(3, 2'b10, "R11");
    chkCfg(1, 2'b10, "R8");
    chkWr(6'b001010, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lockdown();
    t_wpHigh();
    t_history();
    t_ignore();
    t_sameCycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule